// File: doc/BRIEF.md
# Four-Digit Sequence Player with Seven-Segment Output

This block is a Moore state machine with four states. Each state stands for one of four decimal digits, and each digit is set by a module parameter. While the advance input is high, the machine steps to the next state on every rising clock edge. After the last state it wraps back to the first, so the four digits repeat without end. While the advance input is low, the state and every output hold their values.

Each state drives a 4-bit BCD code for its digit. An internal decoder turns that code into the pattern for one seven-segment display. The two state bits also leave the block, so the machine can be watched during bring-up.

Top module: `digit_seq4`

## Requirements
- R1: A synchronous active-high reset puts the machine in state 0, and the digit output then shows the first parameter digit (DIG0).
- R2: With `adv` high at a rising edge, the state goes 0→1→2→3→0, and `digit` shows DIG0, DIG1, DIG2, DIG3 in turn, so the sequence repeats every four clocks.
- R3: With `adv` low at a rising edge, `state_dbg`, `digit` and `seg` all keep their values, however many clocks pass.
- R4: `digit` and `seg` depend only on the current state. Changing `adv` between edges does not change them.
- R5: `seg` is active-high with bit 0 = a through bit 6 = g, and uses standard decimal patterns: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R6: BCD codes 10 to 15 at the decoder input give `seg` = 0 (all segments blank).
- R7: `state_dbg` is the 2-bit binary state index, and it equals the position (0 to 3) of the digit now shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Step enable; when low, the block holds |
| digit | output | 4 | BCD code of the current digit |
| seg | output | 7 | Segment drive, active-high, bit order gfedcba |
| state_dbg | output | 2 | Raw state bits, for debug |

## Verification
The bench runs the block with digits 8, 0, 9 and 3. This puts the widest code, the zero pattern and a wrap back to a 4-bit value into a single loop. A machine that skips or repeats a state, or wraps to the wrong state, would break the period-four sequence. One that looks at `adv` in the output path would show a changed digit when `adv` toggles between edges. A hold that leaks, meaning the state moves while `adv` is low, shows up over a long low stretch. Reset given in the middle of the sequence must return the machine to the first digit. A decoder that leaves codes above 9 lit, or swaps segment bits, is caught by a full sweep of the decoder over all sixteen codes.

// File: rtl/digit_seq4.sv
module digit_seq4 #(
  parameter logic [3:0] DIG0 = 4'd8,
  parameter logic [3:0] DIG1 = 4'd0,
  parameter logic [3:0] DIG2 = 4'd9,
  parameter logic [3:0] DIG3 = 4'd3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  output logic [3:0] digit,
  output logic [6:0] seg,
  output logic [1:0] state_dbg
);
  logic [1:0] st_q;
  logic [1:0] st_d;

  assign st_d = adv ? st_q + 2'd1 : st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= 2'd0;
    else     st_q <= st_d;
  end

  always_comb begin
    case (st_q)
      2'd0:    digit = DIG0;
      2'd1:    digit = DIG1;
      2'd2:    digit = DIG2;
      default: digit = DIG3;
    endcase
  end

  digit_seq4_segdec u_dec (.bcd(digit), .seg(seg));

  assign state_dbg = st_q;
endmodule

module digit_seq4_segdec (
  input  logic [3:0] bcd,
  output logic [6:0] seg
);
  always_comb begin
    case (bcd)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end
endmodule

module digit_seq4_chk (
  input logic       clk,
  input logic       rst,
  input logic       adv,
  input logic [3:0] digit,
  input logic [6:0] seg,
  input logic [1:0] state_dbg
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  a_r1_reset_first: assert property (@(posedge clk) rst |=> state_dbg == 2'd0);
  a_r2_step: assert property (@(posedge clk) disable iff (rst || !live)
    adv |=> state_dbg == $past(state_dbg) + 2'd1);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst || !live)
    !adv |=> $stable(state_dbg) && $stable(digit) && $stable(seg));
  a_r6_valid_code: assert property (@(posedge clk) disable iff (rst)
    digit <= 4'd9 |-> seg != 7'h00);
  a_r4_moore: assert property (@(posedge clk) disable iff (rst || !live)
    $stable(state_dbg) |-> $stable(digit));
endmodule

bind digit_seq4 digit_seq4_chk u_chk (.*);

// File: tb/digit_seq4_tb.sv
module digit_seq4_tb_top;
  logic clk = 0, rst = 1, adv = 0;
  logic [3:0] digit;
  logic [6:0] seg;
  logic [1:0] state_dbg;
  int checks = 0, errors = 0;
  logic [3:0] exp_dig [4] = '{4'd8, 4'd0, 4'd9, 4'd3};

  always #2.5 clk = ~clk;

  digit_seq4 dut_i (.clk(clk), .rst(rst), .adv(adv), .digit(digit),
                    .seg(seg), .state_dbg(state_dbg));

  logic [3:0] sd_bcd;
  logic [6:0] sd_seg;
  digit_seq4_segdec sd_i (.bcd(sd_bcd), .seg(sd_seg));

  function automatic logic [6:0] ref_seg(input logic [3:0] b);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (b > 4'd9) ? 7'h00 : t[b];
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check_pos(input string r, input int p);
    chk(r, state_dbg, p);
    chk(r, digit, exp_dig[p]);
    chk("R5", seg, ref_seg(exp_dig[p]));
  endtask

  task automatic t_reset();
    rst = 1; adv = 0; tick(); tick();
    check_pos("R1", 0);
    rst = 0;
  endtask

  task automatic t_run();
    adv = 1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      check_pos("R2", i % 4);
    end
  endtask

  task automatic t_hold();
    int p;
    adv = 1; tick(); tick(); p = 2;
    check_pos("R7", p);
    adv = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      check_pos("R3", p);
    end
  endtask

  task automatic t_moore();
    int p;
    p = state_dbg;
    adv = 1; #1; chk("R4", digit, exp_dig[p]);
    adv = 0; #1; chk("R4", seg, ref_seg(exp_dig[p]));
    adv = 1; #1; chk("R4", digit, exp_dig[p]);
    tick();
    check_pos("R2", (p + 1) % 4);
    adv = 0;
  endtask

  task automatic t_mid_reset();
    adv = 1; tick();
    rst = 1; tick(); rst = 0;
    check_pos("R1", 0);
    tick(); check_pos("R2", 1);
    adv = 0;
  endtask

  task automatic t_decoder();
    for (int b = 0; b < 16; b++) begin
      sd_bcd = b[3:0]; #1;
      chk(b > 9 ? "R6" : "R5", sd_seg, ref_seg(b[3:0]));
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sd_bcd = 0;
    t_reset();
    t_run();
    t_hold();
    t_moore();
    t_mid_reset();
    t_decoder();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule